// File: doc/BRIEF.md
# Chained Descriptor Memory Copy Engine

This block is a single-channel copy engine. It takes all of its work from control blocks held in memory. Software writes the address of a control block into the start register. The engine then reads the block's source, destination, length and next-block fields from memory and copies that many bytes, one byte at a time. It then jumps to the next block. The chain runs until a block's next pointer is zero. At that point the engine goes idle and raises a sticky done flag.

Each block's fields are read from memory again when that block begins, and nothing is kept from earlier visits. A copy made by an earlier block can therefore change the source, destination, length or next pointer of a later block. A copy of a single byte can change just the low byte of a pointer. Such a chain acts as a self-modifying program. A block whose length is zero moves no data and only redirects the chain.

The register side has one address bit. The memory side is a byte-wide master with a request/acknowledge handshake that carries one beat per access.

Top module: `chain_copy_engine`

## Requirements
- R1: A register write to address 0 while the engine is idle starts a chain. The block address is the written value with its low 5 bits forced to zero. Reading register address 0 returns this current block address.
- R2: A control block is eight 32-bit little-endian words. Only byte offsets 4 to 19 are read: offset 4 is the source, 8 the destination, 12 the length in bytes and 16 the next-block address. Words 0 and 5 to 7 are never read.
- R3: A block of length N reads source+i and then writes destination+i, for i = 0 to N-1 in ascending order. The copy is byte-exact at any byte alignment, and no other byte of memory is written.
- R4: After the last byte of a block, the engine fetches the block at the next-block address (low 5 bits cleared) and runs it.
- R5: A block of length zero makes no data access and passes straight on to its next block.
- R6: The fields of a block are read when that block starts. A write made by an earlier block of the chain to a later block's fields takes effect when that later block runs.
- R7: A next-block address of zero ends the chain. Register address 1 reads bit 0 = active and bit 1 = done. At the end of a chain, active clears and done becomes 1. Done stays set until software writes register address 1 with bit 1 set.
- R8: A write to the start register while active is ignored. The current block address and the running chain are unchanged.
- R9: Writing register address 1 with bit 0 set while active stops the engine. It finishes at most the byte copy in progress, then goes idle with done left clear.
- R10: The memory port makes one access at a time. A request holds its address, write enable and write data steady until the acknowledge. The write enable is high only together with the request.
- R11: After reset the engine is idle, done is clear, the current block address reads zero and no memory request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 start/current block, 1 control/status |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory access is a write |
| memAddr | output | 32 | Byte address |
| memWdata | output | 8 | Write byte |
| memRdata | input | 8 | Read byte, valid with memAck |
| memAck | input | 1 | Access complete |

## Verification
The hardest case to reach from the ports is a chain that rewrites itself. A copy must land on one byte inside a descriptor that has not been fetched yet, and the following block must then use the patched pointer. The bench builds a two-block chain in its memory model. The first block copies one byte onto the low byte of the second block's source field. The bench then checks that the second block reads from the patched address, not the address originally stored. Abort is also hard to place in time. The bench watches its own count of memory writes, issues the abort in the middle of a long copy, and checks that at most one further byte lands.

// File: rtl/cce_pkg.sv
package cce_pkg;
  localparam int CB_WORD_W   = 32;
  localparam int CB_ALIGN    = 5;
  localparam int FIELD_BASE  = 4;
  localparam int FIELD_COUNT = 4;
  localparam int WORD_BYTES  = CB_WORD_W / 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_DISPATCH, ST_READ, ST_WRITE, ST_NEXT
  } engState_t;

  typedef enum logic [1:0] {SEL_DESC, SEL_SRC, SEL_DST} addrSel_t;

  typedef struct packed {
    logic     loadStart;
    logic     loadNext;
    logic     takeFetch;
    logic     takeData;
    logic     stepCopy;
    addrSel_t addrSel;
  } dpCtl_t;
endpackage

// File: rtl/cce_datapath.sv
module cce_datapath
  import cce_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtl_t               ctl,
  input  logic [CB_WORD_W-1:0] startAddr,
  input  logic [7:0]           memRdata,
  output logic [CB_WORD_W-1:0] memAddr,
  output logic [7:0]           memWdata,
  output logic [CB_WORD_W-1:0] cbAddr,
  output logic                 lenZero,
  output logic                 lenOne,
  output logic                 nextZero,
  output logic                 fetchLast
);
  localparam int FETCH_BYTES = FIELD_COUNT * WORD_BYTES;
  localparam int IDX_W       = $clog2(FETCH_BYTES);
  localparam int BSEL_W      = $clog2(WORD_BYTES);

  logic [CB_WORD_W-1:0] srcPtr, dstPtr, lenCnt, nextPtr;
  logic [IDX_W-1:0]     fetchIdx;
  logic [7:0]           dataByte;
  logic [BSEL_W+2:0]    bitBase;

  function automatic logic [CB_WORD_W-1:0] alignDown(input logic [CB_WORD_W-1:0] a);
    return {a[CB_WORD_W-1:CB_ALIGN], {CB_ALIGN{1'b0}}};
  endfunction

  assign bitBase = {fetchIdx[BSEL_W-1:0], 3'b000};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cbAddr   <= '0;
      fetchIdx <= '0;
      srcPtr   <= '0;
      dstPtr   <= '0;
      lenCnt   <= '0;
      nextPtr  <= '0;
      dataByte <= '0;
    end else begin
      if (ctl.loadStart) begin
        cbAddr   <= alignDown(startAddr);
        fetchIdx <= '0;
      end else if (ctl.loadNext) begin
        cbAddr   <= alignDown(nextPtr);
        fetchIdx <= '0;
      end
      if (ctl.takeFetch) begin
        fetchIdx <= fetchIdx + 1'b1;
        case (fetchIdx[IDX_W-1:BSEL_W])
          2'd0:    srcPtr[bitBase +: 8]  <= memRdata;
          2'd1:    dstPtr[bitBase +: 8]  <= memRdata;
          2'd2:    lenCnt[bitBase +: 8]  <= memRdata;
          default: nextPtr[bitBase +: 8] <= memRdata;
        endcase
      end
      if (ctl.takeData) dataByte <= memRdata;
      if (ctl.stepCopy) begin
        srcPtr <= srcPtr + 1'b1;
        dstPtr <= dstPtr + 1'b1;
        lenCnt <= lenCnt - 1'b1;
      end
    end
  end

  always_comb begin
    case (ctl.addrSel)
      SEL_SRC: memAddr = srcPtr;
      SEL_DST: memAddr = dstPtr;
      default: memAddr = cbAddr + CB_WORD_W'(FIELD_BASE) + CB_WORD_W'(fetchIdx);
    endcase
  end

  assign memWdata  = dataByte;
  assign lenZero   = (lenCnt == '0);
  assign lenOne    = (lenCnt == CB_WORD_W'(1));
  assign nextZero  = (nextPtr == '0);
  assign fetchLast = (fetchIdx == IDX_W'(FETCH_BYTES - 1));
endmodule

// File: rtl/cce_control.sv
module cce_control
  import cce_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   regWr,
  input  logic   regAddr,
  input  logic   abortBit,
  input  logic   clearBit,
  input  logic   memAck,
  input  logic   lenZero,
  input  logic   lenOne,
  input  logic   nextZero,
  input  logic   fetchLast,
  output dpCtl_t ctl,
  output logic   memReq,
  output logic   memWe,
  output logic   active,
  output logic   done
);
  engState_t state, stateNx;
  logic abortPend;
  logic chainEnd;

  always_comb begin
    stateNx  = state;
    ctl      = '0;
    chainEnd = 1'b0;
    case (state)
      ST_IDLE: if (regWr && !regAddr) begin
        ctl.loadStart = 1'b1;
        stateNx       = ST_FETCH;
      end
      ST_FETCH: begin
        ctl.addrSel = SEL_DESC;
        if (memAck) begin
          ctl.takeFetch = 1'b1;
          if (abortPend)      stateNx = ST_IDLE;
          else if (fetchLast) stateNx = ST_DISPATCH;
        end
      end
      ST_DISPATCH:
        if (abortPend)    stateNx = ST_IDLE;
        else if (lenZero) stateNx = ST_NEXT;
        else              stateNx = ST_READ;
      ST_READ: begin
        ctl.addrSel = SEL_SRC;
        if (memAck) begin
          ctl.takeData = 1'b1;
          stateNx      = ST_WRITE;
        end
      end
      ST_WRITE: begin
        ctl.addrSel = SEL_DST;
        if (memAck) begin
          ctl.stepCopy = 1'b1;
          if (abortPend)   stateNx = ST_IDLE;
          else if (lenOne) stateNx = ST_NEXT;
          else             stateNx = ST_READ;
        end
      end
      ST_NEXT:
        if (nextZero) begin
          chainEnd = 1'b1;
          stateNx  = ST_IDLE;
        end else if (abortPend) begin
          stateNx = ST_IDLE;
        end else begin
          ctl.loadNext = 1'b1;
          stateNx      = ST_FETCH;
        end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      abortPend <= 1'b0;
      done      <= 1'b0;
    end else begin
      state <= stateNx;
      if (state == ST_IDLE)                               abortPend <= 1'b0;
      else if (regWr && regAddr && abortBit)              abortPend <= 1'b1;
      if (chainEnd)                                       done <= 1'b1;
      else if (regWr && regAddr && clearBit)              done <= 1'b0;
    end
  end

  assign memReq = (state == ST_FETCH) || (state == ST_READ) || (state == ST_WRITE);
  assign memWe  = (state == ST_WRITE);
  assign active = (state != ST_IDLE);
endmodule

// File: rtl/chain_copy_engine.sv
module chain_copy_engine
  import cce_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic        regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [7:0]  memWdata,
  input  logic [7:0]  memRdata,
  input  logic        memAck
);
  dpCtl_t     ctl;
  logic [31:0] cbAddr;
  logic lenZero, lenOne, nextZero, fetchLast, active, done;

  cce_control u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .abortBit(regWdata[0]), .clearBit(regWdata[1]), .memAck(memAck),
    .lenZero(lenZero), .lenOne(lenOne), .nextZero(nextZero),
    .fetchLast(fetchLast), .ctl(ctl), .memReq(memReq), .memWe(memWe),
    .active(active), .done(done)
  );

  cce_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startAddr(regWdata),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .cbAddr(cbAddr), .lenZero(lenZero), .lenOne(lenOne),
    .nextZero(nextZero), .fetchLast(fetchLast)
  );

  assign regRdata = regAddr ? {30'b0, done, active} : cbAddr;
endmodule

// File: rtl/chain_copy_checker.sv
module chain_copy_checker (
  input logic        clk,
  input logic        rstN,
  input logic        regWr,
  input logic        regAddr,
  input logic        memReq,
  input logic        memWe,
  input logic [31:0] memAddr,
  input logic [7:0]  memWdata,
  input logic        memAck,
  input logic        active,
  input logic        done
);
  assert_we_with_req_R10: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memReq);

  assert_hold_until_ack_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> !memReq);

  assert_done_at_chain_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $fell(active));

  assert_start_from_reg_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active) |-> ($past(regWr) && !$past(regAddr)));
endmodule

bind chain_copy_engine chain_copy_checker u_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
  .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
  .memAck(memAck), .active(active), .done(done)
);

// File: tb/chain_copy_engine_test.sv
module chain_copy_engine_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0, regAddr = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic memReq, memWe;
  logic [31:0] memAddr;
  logic [7:0] memWdata;
  logic [7:0] memRdata = '0;
  logic memAck = 1'b0;

  int total = 0, bad = 0;
  int writeCount = 0, trapCount = 0, waitCnt = 0, reqSeq = 0;
  logic [7:0] mem [256];
  logic [7:0] expMem [256];

  always #5 clk = ~clk;

  chain_copy_engine uut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck)
  );

  // memory model: registered acknowledge with a varying wait
  always @(posedge clk) begin
    memAck <= 1'b0;
    if (rstN && memReq && !memAck) begin
      if (waitCnt == 0) begin
        memAck <= 1'b1;
        reqSeq <= reqSeq + 1;
        waitCnt <= reqSeq % 3;
        if (memAddr > 32'd255) trapCount <= trapCount + 1;
        if (memWe) begin
          mem[memAddr[7:0]] <= memWdata;
          writeCount <= writeCount + 1;
        end else begin
          memRdata <= mem[memAddr[7:0]];
          if (memAddr[7] && (memAddr[4:0] < 5'd4 || memAddr[4:0] >= 5'd20))
            trapCount <= trapCount + 1;
        end
      end else waitCnt <= waitCnt - 1;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fillMem(input int seed);
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'((i * 7 + seed * 13) ^ 8'h5a);
      expMem[i] = mem[i];
    end
  endtask

  task automatic putWord(input int a, input logic [31:0] v);
    for (int b = 0; b < 4; b++) begin
      mem[a + b] = v[8*b +: 8];
      expMem[a + b] = v[8*b +: 8];
    end
  endtask

  task automatic putBlock(input int a, input int src, input int dst, input int len, input int nxt);
    putWord(a + 4, 32'(src));
    putWord(a + 8, 32'(dst));
    putWord(a + 12, 32'(len));
    putWord(a + 16, 32'(nxt));
  endtask

  task automatic expCopy(input int src, input int dst, input int len);
    for (int i = 0; i < len; i++) expMem[dst + i] = expMem[src + i];
  endtask

  task automatic regWrite(input logic a, input logic [31:0] v);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = v;
    @(negedge clk);
    regWr = 1'b0; regAddr = 1'b1;
  endtask

  task automatic waitIdle();
    regAddr = 1'b1;
    for (int t = 0; t < 5000; t++) begin
      @(negedge clk);
      if (!regRdata[0]) break;
    end
  endtask

  task automatic compareMem(input string req);
    int miss = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== expMem[i]) miss++;
    check(miss == 0, req, miss, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int wBase, wAbort, wEnd;
    fillMem(0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    regAddr = 1'b1; #1;
    check(regRdata == 32'd0, "R11 status", regRdata, 0);
    check(memReq == 1'b0, "R11 memReq", memReq, 0);
    regAddr = 1'b0; #1;
    check(regRdata == 32'd0, "R11 block address", regRdata, 0);

    // R2 R3 R7 sweep over length and byte alignment
    for (int len = 0; len < 6; len++)
      for (int so = 0; so < 4; so++)
        for (int dOff = 0; dOff < 4; dOff++) begin
          fillMem(len * 16 + so * 4 + dOff);
          putBlock(8'h80, 8'h10 + so, 8'h40 + dOff, len, 0);
          expCopy(8'h10 + so, 8'h40 + dOff, len);
          trapCount = 0;
          regWrite(1'b0, 32'h0000_0080 | 32'(so));
          waitIdle();
          compareMem("R3 byte copy image");
          check(regRdata == 32'd2, "R7 end status", regRdata, 2);
          check(trapCount == 0, "R2 reserved words untouched", trapCount, 0);
          regWrite(1'b1, 32'd2);
          #1 check(regRdata == 32'd0, "R7 done cleared", regRdata, 0);
        end

    // R1 start address alignment and readback
    fillMem(90);
    putBlock(8'h80, 8'h00, 8'h40, 30, 0);
    expCopy(8'h00, 8'h40, 30);
    regWrite(1'b0, 32'h0000_009f);
    regAddr = 1'b0; #1;
    check(regRdata == 32'h80, "R1 aligned block address", regRdata, 32'h80);
    // R8 start while active is ignored
    putBlock(8'hc0, 8'h00, 8'h70, 4, 0);
    regWrite(1'b0, 32'h0000_00c0);
    regAddr = 1'b0; #1;
    check(regRdata == 32'h80, "R8 block address kept", regRdata, 32'h80);
    waitIdle();
    compareMem("R8 second chain not run");

    // R4 R5 chain with zero-length jump in the middle
    fillMem(91);
    putBlock(8'h80, 8'h00, 8'h40, 2, 8'ha0);
    putBlock(8'ha0, 8'h08, 8'h50, 0, 8'hc0);
    putBlock(8'hc0, 8'h20, 8'h60, 3, 0);
    expCopy(8'h00, 8'h40, 2);
    expCopy(8'h20, 8'h60, 3);
    wBase = writeCount;
    regWrite(1'b1, 32'd2);
    regWrite(1'b0, 32'h80);
    waitIdle();
    compareMem("R4 chained image");
    check(writeCount - wBase == 5, "R5 zero-length writes nothing", writeCount - wBase, 5);
    regAddr = 1'b0; #1;
    check(regRdata == 32'hc0, "R4 last block address", regRdata, 32'hc0);

    // R6 self-modifying chain: patch low byte of next block's source
    fillMem(92);
    mem[8'h30] = 8'h10; expMem[8'h30] = 8'h10;
    mem[8'h10] = 8'hab; expMem[8'h10] = 8'hab;
    mem[8'h50] = 8'hcd; expMem[8'h50] = 8'hcd;
    putBlock(8'h80, 8'h30, 8'ha4, 1, 8'ha0);
    putBlock(8'ha0, 8'h50, 8'h60, 1, 0);
    expMem[8'ha4] = 8'h10;
    expMem[8'h60] = 8'hab;
    regWrite(1'b0, 32'h80);
    waitIdle();
    check(mem[8'h60] == 8'hab, "R6 patched source used", mem[8'h60], 8'hab);
    compareMem("R6 image");
    regWrite(1'b1, 32'd2);

    // R9 abort in the middle of a long copy
    fillMem(93);
    putBlock(8'h80, 8'h00, 8'h40, 40, 0);
    wBase = writeCount;
    regWrite(1'b0, 32'h80);
    for (int t = 0; t < 2000; t++) begin
      @(negedge clk);
      if (writeCount - wBase >= 3) break;
    end
    regWrite(1'b1, 32'd1);
    wAbort = writeCount - wBase;
    waitIdle();
    wEnd = writeCount - wBase;
    check(wEnd - wAbort <= 1 && wEnd < 40, "R9 stop after current byte", wEnd - wAbort, 1);
    check(regRdata == 32'd0, "R9 idle without done", regRdata, 0);
    expCopy(8'h00, 8'h40, wEnd);
    compareMem("R9 partial image");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule